// File: doc/BRIEF.md
# Periodic Reload Timer

This block is a down/up counter that repeats a programmable period without software help. Software writes a reload value and a control word over a small register bus. Once enabled, the counter advances by one step on every cycle where the selected tick source is high. When it reaches its terminal value it takes the reload value again and raises a sticky interrupt flag. Software can read the live count at any time and clears the flag by writing a dedicated register.

The counter takes its start value as soon as the timer is enabled or the reload register is written. As a result, the first interrupt after enabling comes one programmed period later, whichever tick source is selected. It never waits for a full wrap of the counter. Tick sources are clock-enable strobes from outside, for example a prescaled system clock and a slow low-power clock. They are selected by a control field.

Top module: `prd_timer`

## Requirements
- R1: After reset the count, reload value and control word all read as zero and `irq_o` is low.
- R2: A bus write to address 0 (reload) stores the data and places it in the count on the next cycle. A write to address 2 (control) that sets bit 0 while the timer is disabled places the stored reload value in the count on the next cycle.
- R3: With control bit 1 clear (count down), each qualifying tick decrements the count. A qualifying tick at count 0 instead reloads the count, so one period is reload+1 ticks.
- R4: The count holds when control bit 0 (enable) is clear, or when the tick input selected by control bits [2+] is low. Ticks on an unselected input have no effect.
- R5: A qualifying tick at the terminal count sets the interrupt flag, and `irq_o` is high on the next cycle.
- R6: After the timer is enabled with reload value L, the first interrupt follows exactly L+1 qualifying ticks, for every tick source.
- R7: With control bit 1 set (count up), each qualifying tick increments the count. A qualifying tick at all-ones reloads the count, so one period is (all-ones − reload)+1 ticks.
- R8: The flag stays set until a write to address 3 with data bit 0 set. A write with bit 0 clear has no effect. A terminal tick in the same cycle as the clearing write leaves the flag set.
- R9: Address 1 returns the live count, and address 3 returns the flag in bit 0. Writes to address 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | CNT_W (16) | Write data |
| bus_rdata_o | output | CNT_W (16) | Read data of the addressed register (combinational) |
| tick_src_i | input | N_SRC (2) | Tick strobes, one per clock source |
| irq_o | output | 1 | Sticky period-end interrupt |

## Verification
The properties assume that tick strobes and bus writes are synchronous single-cycle levels sampled at the clock edge. They also assume that one write carries one address, so a reload load and an enabling control write never coincide. The bench drives every input one time unit after a rising edge, issues at most one write per cycle, and raises only the tick bits it names. Terminal ticks, clearing writes and reload writes are placed in chosen cycles, including the one case that deliberately overlaps a clear with a terminal tick.

// File: rtl/prd_timer_pkg.sv
package prd_timer_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_RELOAD = 2'd0,
    REG_COUNT  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_FLAG   = 2'd3
  } reg_addr_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_UP_BIT  = 1;
  localparam int CTRL_SEL_LSB = 2;
  localparam int FLAG_CLR_BIT = 0;
endpackage

// File: rtl/prd_timer_rst_sync.sv
module prd_timer_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/prd_timer_regs.sv
module prd_timer_regs
  import prd_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEL_W = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              flag_i,
  output logic [CNT_W-1:0]  reload_o,
  output logic              en_o,
  output logic              up_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic              load_o,
  output logic [CNT_W-1:0]  load_val_o,
  output logic              clr_o
);
  localparam int CTRL_W = CTRL_SEL_LSB + SEL_W;

  logic [CNT_W-1:0] reload_q, reload_d;
  logic             en_q, en_d, up_q, up_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             wr_reload, wr_ctrl;
  logic [CTRL_W-1:0] ctrl_rd;

  assign wr_reload = wr_i && (addr_i == REG_RELOAD);
  assign wr_ctrl   = wr_i && (addr_i == REG_CTRL);

  always_comb begin
    reload_d = reload_q;
    en_d     = en_q;
    up_d     = up_q;
    sel_d    = sel_q;
    if (wr_reload) reload_d = wdata_i;
    if (wr_ctrl) begin
      en_d  = wdata_i[CTRL_EN_BIT];
      up_d  = wdata_i[CTRL_UP_BIT];
      sel_d = wdata_i[CTRL_SEL_LSB +: SEL_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '0;
      en_q     <= 1'b0;
      up_q     <= 1'b0;
      sel_q    <= '0;
    end else begin
      reload_q <= reload_d;
      en_q     <= en_d;
      up_q     <= up_d;
      sel_q    <= sel_d;
    end
  end

  always_comb begin
    load_o     = 1'b0;
    load_val_o = reload_q;
    if (wr_reload) begin
      load_o     = 1'b1;
      load_val_o = wdata_i;
    end else if (wr_ctrl && wdata_i[CTRL_EN_BIT] && !en_q) begin
      load_o     = 1'b1;
    end
  end

  assign clr_o = wr_i && (addr_i == REG_FLAG) && wdata_i[FLAG_CLR_BIT];

  always_comb begin
    ctrl_rd = '0;
    ctrl_rd[CTRL_EN_BIT] = en_q;
    ctrl_rd[CTRL_UP_BIT] = up_q;
    ctrl_rd[CTRL_SEL_LSB +: SEL_W] = sel_q;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_RELOAD: rdata_o = reload_q;
      REG_COUNT:  rdata_o = count_i;
      REG_CTRL:   rdata_o[CTRL_W-1:0] = ctrl_rd;
      default:    rdata_o[FLAG_CLR_BIT] = flag_i;
    endcase
  end

  assign reload_o = reload_q;
  assign en_o     = en_q;
  assign up_o     = up_q;
  assign sel_o    = sel_q;
endmodule

// File: rtl/prd_timer_core.sv
module prd_timer_core #(
  parameter int CNT_W = 16,
  parameter int N_SRC = 2,
  parameter int SEL_W = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] tick_src_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             en_i,
  input  logic             up_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o,
  output logic             term_o
);
  localparam int PAD_N = 1 << SEL_W;

  logic [PAD_N-1:0] tick_pad;
  logic [CNT_W-1:0] count_q, count_d, term_val;
  logic             adv, at_term;

  genvar gi;
  generate
    for (gi = 0; gi < PAD_N; gi++) begin : g_pad
      if (gi < N_SRC) begin : g_src
        assign tick_pad[gi] = tick_src_i[gi];
      end else begin : g_none
        assign tick_pad[gi] = 1'b0;
      end
    end
  endgenerate

  assign adv      = en_i && tick_pad[sel_i];
  assign term_val = up_i ? {CNT_W{1'b1}} : {CNT_W{1'b0}};
  assign at_term  = (count_q == term_val);

  always_comb begin
    count_d = count_q;
    if (load_i)       count_d = load_val_i;
    else if (adv) begin
      if (at_term)    count_d = reload_i;
      else if (up_i)  count_d = count_q + 1'b1;
      else            count_d = count_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign term_o  = adv && at_term && !load_i;
  assign count_o = count_q;
endmodule

// File: rtl/prd_timer_irq.sv
module prd_timer_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/prd_timer.sv
module prd_timer
  import prd_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_SRC = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [CNT_W-1:0] bus_wdata_i,
  output logic [CNT_W-1:0] bus_rdata_o,
  input  logic [N_SRC-1:0] tick_src_i,
  output logic             irq_o
);
  localparam int SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic             rst_sync_n;
  logic [CNT_W-1:0] reload_q, load_val, count;
  logic             en_q, up_q, load_evt, clr_req, term_evt, flag;
  logic [SEL_W-1:0] sel_q;

  prd_timer_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  prd_timer_regs #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n),
    .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .rdata_o(bus_rdata_o), .count_i(count), .flag_i(flag),
    .reload_o(reload_q), .en_o(en_q), .up_o(up_q), .sel_o(sel_q),
    .load_o(load_evt), .load_val_o(load_val), .clr_o(clr_req)
  );

  prd_timer_core #(.CNT_W(CNT_W), .N_SRC(N_SRC), .SEL_W(SEL_W)) u_core (
    .clk(clk), .rst_n(rst_sync_n), .tick_src_i(tick_src_i), .sel_i(sel_q),
    .en_i(en_q), .up_i(up_q), .reload_i(reload_q), .load_i(load_evt),
    .load_val_i(load_val), .count_o(count), .term_o(term_evt)
  );

  prd_timer_irq u_irq (
    .clk(clk), .rst_n(rst_sync_n), .set_i(term_evt), .clr_i(clr_req),
    .flag_o(flag)
  );

  assign irq_o = flag;
endmodule

// File: rtl/prd_timer_chk.sv
module prd_timer_chk #(
  parameter int CNT_W = 16,
  parameter int N_SRC = 2,
  parameter int SEL_W = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr,
  input logic [1:0]       addr,
  input logic [CNT_W-1:0] wdata,
  input logic [N_SRC-1:0] ticks,
  input logic [SEL_W-1:0] sel,
  input logic             en,
  input logic             up,
  input logic [CNT_W-1:0] reload,
  input logic [CNT_W-1:0] count,
  input logic             irq
);
  logic [N_SRC-1:0] shifted;
  logic             qual, ld, at_end, clr;

  assign shifted = ticks >> sel;
  assign qual    = en && shifted[0];
  assign ld      = wr && ((addr == 2'd0) || ((addr == 2'd2) && wdata[0] && !en));
  assign at_end  = up ? (count == {CNT_W{1'b1}}) : (count == '0);
  assign clr     = wr && (addr == 2'd3) && wdata[0];

  AST_RELOAD_WR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr && addr == 2'd0 |=> count == $past(wdata)); // R2
  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    qual && !up && !at_end && !ld |=> count == CNT_W'($past(count) - 1'b1)); // R3
  AST_END_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    qual && at_end && !ld |=> count == $past(reload)); // R3
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !qual && !ld |=> $stable(count)); // R4
  AST_IRQ_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    qual && at_end && !ld |=> irq); // R5
  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    qual && up && !at_end && !ld |=> count == CNT_W'($past(count) + 1'b1)); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr |=> irq); // R8
  AST_IRQ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !(qual && at_end && !ld) |=> !irq); // R8
  AST_COUNT_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr && addr == 2'd1 && !qual |=> $stable(count)); // R9
endmodule

bind prd_timer prd_timer_chk #(.CNT_W(CNT_W), .N_SRC(N_SRC), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr(bus_wr_i), .addr(bus_addr_i),
  .wdata(bus_wdata_i), .ticks(tick_src_i), .sel(sel_q), .en(en_q), .up(up_q),
  .reload(reload_q), .count(count), .irq(irq_o)
);

// File: tb/tb_prd_timer.sv
module tb_prd_timer;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 16;
  localparam int N_SRC = 2;

  logic             clk, rst_n, bus_wr;
  logic [1:0]       bus_addr;
  logic [CNT_W-1:0] bus_wdata, bus_rdata;
  logic [N_SRC-1:0] ticks;
  logic             irq;
  int               errors = 0;
  int               checks = 0;
  bit               done = 0;

  prd_timer #(.CNT_W(CNT_W), .N_SRC(N_SRC)) dut (
    .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
    .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .tick_src_i(ticks),
    .irq_o(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one clock cycle with optional write and tick strobes; inputs drop after the edge
  task automatic cyc(input logic wr, input logic [1:0] a, input logic [CNT_W-1:0] d, input logic [N_SRC-1:0] t);
    bus_wr = wr; bus_addr = a; bus_wdata = d; ticks = t;
    @(posedge clk); #1;
    bus_wr = 1'b0; ticks = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [CNT_W-1:0] v);
    bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic expect_count(input string req, input logic [CNT_W-1:0] exp);
    logic [CNT_W-1:0] v;
    rd(2'd1, v); check(req, v, exp);
  endtask

  task automatic t_reset;
    logic [CNT_W-1:0] v;
    rd(2'd0, v); check("R1 reload", v, 16'h0);
    rd(2'd1, v); check("R1 count", v, 16'h0);
    rd(2'd2, v); check("R1 ctrl", v, 16'h0);
    check("R1 irq", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_first_period_slow; // R2 R3 R5 R6
    cyc(1, 2'd0, 16'd3, '0);
    cyc(1, 2'd2, 16'h5, '0);           // enable, down, source 1
    expect_count("R2 enable loads", 16'd3);
    for (int i = 0; i < 3; i++) cyc(0, 2'd0, 0, 2'b10);
    expect_count("R3 reached zero", 16'd0);
    check("R6 no early irq", {15'd0, irq}, 16'h0);
    cyc(0, 2'd0, 0, 2'b10);
    expect_count("R3 reload at zero", 16'd3);
    check("R6 irq after L+1 ticks", {15'd0, irq}, 16'h1);
    cyc(1, 2'd3, 16'h1, '0);
    check("R8 cleared", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_ignore; // R4 R2
    cyc(0, 2'd0, 0, 2'b01);            // unselected source
    expect_count("R4 unselected source", 16'd3);
    cyc(0, 2'd0, 0, 2'b10);
    expect_count("R3 decrement", 16'd2);
    cyc(1, 2'd2, 16'h4, '0);           // disable
    cyc(0, 2'd0, 0, 2'b11);
    expect_count("R4 disabled holds", 16'd2);
    cyc(1, 2'd2, 16'h5, '0);           // re-enable
    expect_count("R2 enable reloads", 16'd3);
    cyc(1, 2'd0, 16'd10, 2'b10);        // reload write beats the tick
    expect_count("R2 reload write restarts", 16'd10);
    check("R5 no irq on restart", {15'd0, irq}, 16'h0);
  endtask

  task automatic t_up_and_clear; // R7 R8 R9
    logic [CNT_W-1:0] v;
    cyc(1, 2'd2, 16'h3, '0);           // enable, up, source 0 (no reload)
    expect_count("R2 no load when already on", 16'd10);
    cyc(1, 2'd0, 16'hFFFD, '0);
    cyc(0, 2'd0, 0, 2'b01);
    cyc(0, 2'd0, 0, 2'b01);
    expect_count("R7 at full scale", 16'hFFFF);
    check("R7 no early irq", {15'd0, irq}, 16'h0);
    cyc(0, 2'd0, 0, 2'b01);
    expect_count("R7 reload at full scale", 16'hFFFD);
    check("R5 irq up mode", {15'd0, irq}, 16'h1);
    cyc(1, 2'd3, 16'h1, '0);
    cyc(0, 2'd0, 0, 2'b01);
    cyc(0, 2'd0, 0, 2'b01);
    cyc(1, 2'd3, 16'h1, 2'b01);         // clear collides with period end
    check("R8 set wins over clear", {15'd0, irq}, 16'h1);
    cyc(1, 2'd3, 16'h2, '0);
    check("R8 bit0 clear ignored", {15'd0, irq}, 16'h1);
    rd(2'd3, v); check("R9 flag readback", v, 16'h1);
    cyc(1, 2'd3, 16'h1, '0);
    check("R8 clear works", {15'd0, irq}, 16'h0);
    cyc(1, 2'd1, 16'h1234, '0);
    expect_count("R9 count write ignored", 16'hFFFD);
    rd(2'd2, v); check("R9 ctrl readback", v, 16'h3);
  endtask

  initial begin
    bus_wr = 0; bus_addr = 0; bus_wdata = 0; ticks = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    t_reset();
    t_first_period_slow();
    t_ignore();
    t_up_and_clear();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule